// File: doc/BRIEF.md
# SMBus Alert Line Monitor

This block watches the alert wire of a two-wire system-management bus for a controller acting as bus host. The pin arrives asynchronously. A chain of flip-flops brings it into the system clock domain, and a one-sample history register then finds high-to-low transitions. Each such transition latches a sticky alert flag, but only when both host mode and alert monitoring are enabled.

Software sees the flag and removes it with a one-cycle clear strobe. An interrupt request follows the flag while the error-interrupt enable is high. When alert monitoring is off, the block treats the internal alert line as high whatever level the pin has. It also signals that the pin may then serve as an ordinary I/O.

The history register always follows the synchronised pin, even while monitoring is off. For that reason, turning monitoring on while the pin is already low produces no alert.

Top module: `smb_alert_mon`

## Requirements
- R1: While reset is asserted and directly after it is released, alert_flag_o and irq_o are 0. The synchroniser and the edge history start high.
- R2: With host_en_i=1 and alert_en_i=1, a high-to-low change of alert_pin_i sets alert_flag_o. The flag becomes visible after the third rising clock edge following the change: two synchroniser stages and one flag register.
- R3: A pin held low sets the flag at most once. After a clear, a pin that stays low does not set it again.
- R4: A falling edge that occurs while host_en_i=0 or alert_en_i=0 leaves alert_flag_o at 0.
- R5: With alert_en_i=0 the effective alert line is high. Setting alert_en_i to 1 while the pin is already low does not set the flag.
- R6: irq_o equals 1 exactly when alert_flag_o=1 and err_irq_en_i=1, in the same cycle.
- R7: pin_gpio_o is 1 exactly when alert_en_i=0.
- R8: A one-cycle flag_clr_i=1 clears the flag at the next rising edge. If a detected edge coincides with the clear, the flag stays 1.
- R9: Once set, the flag stays 1 until a clear, even after the pin returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alert_pin_i | input | 1 | Raw asynchronous alert pin level |
| host_en_i | input | 1 | Controller is in bus host mode |
| alert_en_i | input | 1 | Alert monitoring enable |
| err_irq_en_i | input | 1 | Error interrupt enable |
| flag_clr_i | input | 1 | One-cycle software clear of the alert flag |
| alert_flag_o | output | 1 | Sticky alert status flag |
| irq_o | output | 1 | Interrupt request |
| pin_gpio_o | output | 1 | Alert pin is free for general-purpose use |

## Verification
On every cycle, the assertions check several properties. A detected edge always sets the flag on the next cycle, and a detected edge never lasts two cycles in a row. A set flag holds until it is cleared, and a clear without a coinciding edge empties the flag. With detection gated off, an empty flag stays empty, and the interrupt never rises without its enable. The exact three-edge latency from the pin, and the refusal to flag a pin that is already low when monitoring is switched on, can only be shown by the bench's timed pin sequences. The same holds for the single alert given by a pin held low through a clear, and for the collision of a clear with an edge.

// File: rtl/smba_pkg.sv
package smba_pkg;

    parameter int unsigned SYNC_STAGES_DEF = 2;

    typedef struct packed {
        logic hist;
    } edge_st_t;

    typedef struct packed {
        logic flag;
    } flag_st_t;

endpackage

// File: rtl/smba_sync.sv
module smba_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                chain_d = d_i;
            end
        end else begin : g_chain
            always_comb begin
                chain_d = {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/smba_edge.sv
module smba_edge
    import smba_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic host_en_i,
    input  logic mon_en_i,
    output logic fall_o
);

    edge_st_t st_d;
    edge_st_t st_q;
    logic     eff_line;

    always_comb begin
        eff_line  = mon_en_i ? line_i : 1'b1;
        st_d      = st_q;
        st_d.hist = line_i;
        fall_o    = host_en_i & st_q.hist & ~eff_line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hist <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: a held low level yields a single-cycle edge, never two in a row
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/smba_flag.sv
module smba_flag
    import smba_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fall_i,
    input  logic clr_i,
    output logic flag_o
);

    flag_st_t st_d;
    flag_st_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = fall_i | (st_q.flag & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    // R2: a detected edge always latches the flag
    a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fall_i |=> flag_o);

    // R8: a clear without a coinciding edge empties the flag
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && clr_i && !fall_i) |=> !flag_o);

    // R9: the flag is sticky until cleared
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/smb_alert_mon.sv
module smb_alert_mon
    import smba_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alert_pin_i,
    input  logic host_en_i,
    input  logic alert_en_i,
    input  logic err_irq_en_i,
    input  logic flag_clr_i,
    output logic alert_flag_o,
    output logic irq_o,
    output logic pin_gpio_o
);

    logic pin_sync;
    logic fall;

    smba_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (alert_pin_i),
        .q_o   (pin_sync)
    );

    smba_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (pin_sync),
        .host_en_i (host_en_i),
        .mon_en_i  (alert_en_i),
        .fall_o    (fall)
    );

    smba_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .fall_i (fall),
        .clr_i  (flag_clr_i),
        .flag_o (alert_flag_o)
    );

    assign irq_o      = alert_flag_o & err_irq_en_i;
    assign pin_gpio_o = ~alert_en_i;

    // R4: with detection gated off an empty flag stays empty
    a_r4_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
        ((!host_en_i || !alert_en_i) && !alert_flag_o) |=> !alert_flag_o);

    // R6: the request never rises without its enable
    a_r6_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> err_irq_en_i);

    // R1: nothing is flagged while reset is held
    always_comb begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!alert_flag_o);
        end
    end

endmodule

// File: tb/smb_alert_mon_test.sv
module smb_alert_mon_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin = 1'b1;
    logic host = 1'b0;
    logic aen = 1'b0;
    logic ien = 1'b0;
    logic clr = 1'b0;
    logic flag_o;
    logic irq_o;
    logic gpio_o;

    int checks = 0;
    int failures = 0;
    bit reported = 1'b0;

    typedef struct {
        logic  flag;
        logic  irq;
        logic  gpio;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    // reference state: two sync samples, edge history, flag
    logic m_s1 = 1'b1;
    logic m_s2 = 1'b1;
    logic m_h  = 1'b1;
    logic m_f  = 1'b0;

    always #10 clk = ~clk;

    smb_alert_mon uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .alert_pin_i  (pin),
        .host_en_i    (host),
        .alert_en_i   (aen),
        .err_irq_en_i (ien),
        .flag_clr_i   (clr),
        .alert_flag_o (flag_o),
        .irq_o        (irq_o),
        .pin_gpio_o   (gpio_o)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // driver: apply one cycle of inputs, predict outputs after the next edge
    task automatic step(input logic p, input logic h, input logic a, input logic ie,
                        input logic c, input string tag);
        logic fall;
        exp_t e;
        @(negedge clk);
        pin = p; host = h; aen = a; ien = ie; clr = c;
        fall = h & a & m_h & ~m_s2;
        m_h  = m_s2;
        m_s2 = m_s1;
        m_s1 = p;
        m_f  = fall | (m_f & ~c);
        e.flag = m_f;
        e.irq  = m_f & ie;
        e.gpio = ~a;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compare in the high phase after each edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, "flag", flag_o, e.flag);
                check(e.tag, "irq",  irq_o,  e.irq);
                check(e.tag, "gpio", gpio_o, e.gpio);
            end
        end
    end

    // explicit latency check helper: exact edge count for flag
    task automatic expect_flag_now(input logic v, input string tag);
        @(posedge clk);
        #5;
        check(tag, "flag_direct", flag_o, v);
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #5;
        check("R1", "flag_in_reset", flag_o, 1'b0);
        check("R1", "irq_in_reset", irq_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "flag_after_reset", flag_o, 1'b0);
        check("R1", "irq_after_reset", irq_o, 1'b0);
        check("R7", "gpio_after_reset", gpio_o, 1'b1);

        // R2 falling edge sets flag, idle high first
        repeat (4) step(1, 1, 1, 1, 0, "R2");
        step(0, 1, 1, 1, 0, "R2");
        step(0, 1, 1, 1, 0, "R2");
        step(0, 1, 1, 1, 0, "R2");
        // R9 sticky after pin high again
        repeat (4) step(1, 1, 1, 1, 0, "R9");
        // R6 irq masked by enable
        step(1, 1, 1, 0, 0, "R6");
        step(1, 1, 1, 1, 0, "R6");
        // R8 clear
        step(1, 1, 1, 1, 1, "R8");
        step(1, 1, 1, 1, 0, "R8");

        // R3 held low: flag once, clear, stays clear
        step(0, 1, 1, 1, 0, "R3");
        repeat (3) step(0, 1, 1, 1, 0, "R3");
        step(0, 1, 1, 1, 1, "R3");
        repeat (5) step(0, 1, 1, 1, 0, "R3");
        repeat (3) step(1, 1, 1, 1, 0, "R3");

        // R4 monitoring off: edge ignored, R7 gpio high
        repeat (3) step(1, 1, 0, 1, 0, "R7");
        repeat (5) step(0, 1, 0, 1, 0, "R4");
        // R5 enable while low: no spurious alert
        repeat (5) step(0, 1, 1, 1, 0, "R5");
        repeat (3) step(1, 1, 1, 1, 0, "R5");
        // R4 host mode off: edge ignored
        repeat (5) step(0, 0, 1, 1, 0, "R4");
        repeat (3) step(1, 0, 1, 1, 0, "R4");

        // R8 edge coinciding with clear: first set the flag
        repeat (4) step(0, 1, 1, 1, 0, "R8");
        repeat (3) step(1, 1, 1, 1, 0, "R8");
        step(0, 1, 1, 1, 0, "R8");
        step(0, 1, 1, 1, 0, "R8");
        step(0, 1, 1, 1, 1, "R8");   // edge detected this cycle, clear too
        repeat (3) step(0, 1, 1, 1, 0, "R8");
        step(1, 1, 1, 1, 1, "R8");
        step(1, 1, 1, 1, 0, "R8");

        // R2 exact latency measured directly: flag rises at the third edge
        repeat (3) @(posedge clk);
        #5;
        @(negedge clk);
        pin = 1'b0;
        expect_flag_now(1'b0, "R2");
        expect_flag_now(1'b0, "R2");
        expect_flag_now(1'b1, "R2");

        repeat (3) @(posedge clk);
        report();
    end

endmodule